// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier (radix-2)

This block multiplies two two's-complement operands over several clock cycles. It handles one recoded multiplier bit per cycle. The datapath has three working registers. An upper accumulator, one bit wider than the operand, collects the partial sums. A lower register receives the bits that are shifted out of the accumulator. A multiplier register is rotated in a circle, so the multiplier needs no second copy. A single history bit holds the multiplier bit that last left the low end of that register.

In each step the block looks at the pair formed by the multiplier register's low bit and the history bit. From that pair it leaves the accumulator unchanged, adds the multiplicand, or subtracts it. The accumulator and the lower register are then shifted right together as one arithmetic shift. After exactly WIDTH steps, the 2·WIDTH-bit signed product is the low WIDTH bits of the accumulator joined with the lower register.

A one-cycle start pulse begins an operation. The block then reports busy for WIDTH cycles. A one-cycle done flag marks the cycle in which the product first becomes valid.

Top module: `booth_seq_mult`

## Requirements
- R1: While reset is held, and in the first cycle after it, busy_o and done_o are 0 and product_o is 0.
- R2: When start_i is high at a clock edge while busy_o is 0, the operands are captured. busy_o is 1 after that edge, and product_o reads 0 because both the accumulator and the lower register are cleared.
- R3: Each step recodes the pair {multiplier LSB, history bit}. Pair 00 or 11 means shift only, 01 adds the multiplicand, and 10 subtracts it. The history bit starts at 0. With multiplicand 1, product_o after step 1 and step 2 is F8/04 for multiplier 1, F8/FC for multiplier 3, and 00/F8 for multiplier 2 (8-bit hex values, WIDTH 4).
- R4: When done_o is 1, product_o equals the signed product of the captured operands for every operand pair. This includes the most negative value times itself.
- R5: busy_o stays 1 for exactly WIDTH cycles after the capturing edge. done_o is 1 for exactly one cycle, starting at the edge on which busy_o falls.
- R6: start_i, and any change on the operand inputs, has no effect while busy_o is 1. The result of the running operation is unchanged.
- R7: While idle with start_i low, product_o holds the last result.
- R8: A start_i that is high during the done_o cycle is accepted at the next edge, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation when idle |
| mcand_i | input | WIDTH | Signed multiplicand |
| mplier_i | input | WIDTH | Signed multiplier |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle flag: product valid |
| product_o | output | 2*WIDTH | Signed product |

## Verification
Two functions can fall in the same cycle: the done flag of one operation and the acceptance of the next start. The bench holds start_i high without a break, from the first capture through the whole operation, and changes the operands while it is busy. This checks that the final step ignores the request (R6). It also checks that the correct product is presented during the done cycle, and that the new operands are captured on the following edge with product_o cleared (R8, R2). The cycle of every busy, done and product sample is computed in the bench from the capture edge.

// File: rtl/booth_pkg.sv
package booth_pkg;

   typedef enum logic [1:0] {
      BOOTH_KEEP = 2'b00,
      BOOTH_ADD  = 2'b01,
      BOOTH_SUB  = 2'b10
   } booth_op_e;

endpackage

// File: rtl/booth_recode.sv
// Radix-2 recoding of {current multiplier bit, history bit}.
module booth_recode
   import booth_pkg::*;
(
   input  logic      bit_i,
   input  logic      hist_i,
   output booth_op_e op_o
);

   always_comb begin
      unique case ({bit_i, hist_i})
         2'b01:   op_o = BOOTH_ADD;
         2'b10:   op_o = BOOTH_SUB;
         default: op_o = BOOTH_KEEP;
      endcase
   end

   // R3: a pair whose two bits agree never produces an arithmetic action
   always_comb begin
      if (bit_i == hist_i) begin
         p_equal_pair_keeps_r3: assert (op_o == BOOTH_KEEP);
      end
   end

endmodule

// File: rtl/booth_addsub.sv
// Accumulator update: keep, add or subtract the sign-extended multiplicand.
module booth_addsub
   import booth_pkg::*;
#(
   parameter int WIDTH     = 4,
   parameter int ACC_W     = WIDTH + 1,
   parameter bit SHARED_AD = 1'b1
) (
   input  logic [ACC_W-1:0] acc_i,
   input  logic [WIDTH-1:0] mcand_i,
   input  booth_op_e        op_i,
   output logic [ACC_W-1:0] sum_o
);

   localparam int EXT_W = ACC_W - WIDTH;

   if (ACC_W <= WIDTH) begin : g_bad_acc
      $error("booth_addsub: ACC_W must exceed WIDTH");
   end

   logic [ACC_W-1:0] mcand_ext;
   assign mcand_ext = {{EXT_W{mcand_i[WIDTH-1]}}, mcand_i};

   if (SHARED_AD) begin : g_shared
      // one adder, operand inverted with carry-in for subtraction
      logic             do_sub;
      logic [ACC_W-1:0] operand;
      logic [ACC_W-1:0] total;
      assign do_sub  = (op_i == BOOTH_SUB);
      assign operand = do_sub ? ~mcand_ext : mcand_ext;
      assign total   = acc_i + operand + ACC_W'(do_sub);
      assign sum_o   = (op_i == BOOTH_KEEP) ? acc_i : total;
   end else begin : g_split
      // separate adder and subtractor, selected after both resolve
      logic [ACC_W-1:0] plus;
      logic [ACC_W-1:0] minus;
      assign plus  = acc_i + mcand_ext;
      assign minus = acc_i - mcand_ext;
      always_comb begin
         unique case (op_i)
            BOOTH_ADD: sum_o = plus;
            BOOTH_SUB: sum_o = minus;
            default:   sum_o = acc_i;
         endcase
      end
   end

endmodule

// File: rtl/booth_seq_ctrl.sv
// Step counter and busy/done sequencing.
module booth_seq_ctrl #(
   parameter int WIDTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic load_o,
   output logic step_o,
   output logic busy_o,
   output logic done_o
);

   localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             done_q;
   logic             last;

   assign load_o = start_i && !busy_q;
   assign step_o = busy_q;
   assign last   = busy_q && (cnt_q == LAST_STEP);
   assign busy_o = busy_q;
   assign done_o = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= last;
         if (load_o) begin
            cnt_q  <= '0;
            busy_q <= 1'b1;
         end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (last) begin
               busy_q <= 1'b0;
            end
         end
      end
   end

   // R5: done lasts a single cycle
   p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R5: busy falls exactly when done rises
   p_busy_fall_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> done_q);

   // R5: the step count advances by one per busy cycle
   p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !last) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

   // R6: a start during busy never restarts the count
   p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start_i && cnt_q != '0) |=> (cnt_q != '0 || !busy_q));

endmodule

// File: rtl/booth_seq_mult.sv
// Sequential radix-2 signed multiplier with rotating multiplier register.
module booth_seq_mult
   import booth_pkg::*;
#(
   parameter int WIDTH     = 4,
   parameter bit SHARED_AD = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [WIDTH-1:0]   mcand_i,
   input  logic [WIDTH-1:0]   mplier_i,
   output logic               busy_o,
   output logic               done_o,
   output logic [2*WIDTH-1:0] product_o
);

   localparam int ACC_W = WIDTH + 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("booth_seq_mult: WIDTH must be at least 2");
   end

   logic [ACC_W-1:0] acc_q;
   logic [WIDTH-1:0] low_q;
   logic [WIDTH-1:0] mpl_q;
   logic [WIDTH-1:0] mcd_q;
   logic             hist_q;

   logic             load;
   logic             step;
   booth_op_e        op;
   logic [ACC_W-1:0] sum;

   booth_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .load_o  (load),
      .step_o  (step),
      .busy_o  (busy_o),
      .done_o  (done_o)
   );

   booth_recode u_recode (
      .bit_i  (mpl_q[0]),
      .hist_i (hist_q),
      .op_o   (op)
   );

   booth_addsub #(
      .WIDTH     (WIDTH),
      .ACC_W     (ACC_W),
      .SHARED_AD (SHARED_AD)
   ) u_addsub (
      .acc_i   (acc_q),
      .mcand_i (mcd_q),
      .op_i    (op),
      .sum_o   (sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         low_q  <= '0;
         mpl_q  <= '0;
         mcd_q  <= '0;
         hist_q <= 1'b0;
      end else if (load) begin
         acc_q  <= '0;
         low_q  <= '0;
         mpl_q  <= mplier_i;
         mcd_q  <= mcand_i;
         hist_q <= 1'b0;
      end else if (step) begin
         // arithmetic right shift of {acc, low}, circular shift of multiplier
         acc_q  <= {sum[ACC_W-1], sum[ACC_W-1:1]};
         low_q  <= {sum[0], low_q[WIDTH-1:1]};
         mpl_q  <= {mpl_q[0], mpl_q[WIDTH-1:1]};
         hist_q <= mpl_q[0];
      end
   end

   assign product_o = {acc_q[WIDTH-1:0], low_q};

   // R2: an accepted start clears the visible product and raises busy
   p_load_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && product_o == '0));

   // R7: idle without a start leaves the result untouched
   p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(product_o));

   // R4: the final accumulator guard bit agrees with the product sign
   p_product_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (acc_q[ACC_W-1] == acc_q[WIDTH-1]));

   // R3: the history bit tracks the bit rotated out on the previous step
   p_hist_tracks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !load) |=> (hist_q == mpl_q[WIDTH-1]));

endmodule

// File: tb/test_booth_seq_mult.sv
module test_booth_seq_mult;

   logic clk = 1'b0;
   logic rst_n = 1'b0;

   logic       start4 = 1'b0;
   logic [3:0] a4 = '0;
   logic [3:0] b4 = '0;
   logic       busy4;
   logic       done4;
   logic [7:0] prod4;

   logic        start8 = 1'b0;
   logic [7:0]  a8 = '0;
   logic [7:0]  b8 = '0;
   logic        busy8;
   logic        done8;
   logic [15:0] prod8;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   booth_seq_mult #(.WIDTH(4)) i_booth_seq_mult (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start4),
      .mcand_i   (a4),
      .mplier_i  (b4),
      .busy_o    (busy4),
      .done_o    (done4),
      .product_o (prod4)
   );

   booth_seq_mult #(.WIDTH(8), .SHARED_AD(1'b0)) i_booth_seq_mult_w8 (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start8),
      .mcand_i   (a8),
      .mplier_i  (b8),
      .busy_o    (busy8),
      .done_o    (done8),
      .product_o (prod8)
   );

   // corner operands for the 8-bit instance: {multiplicand, multiplier}
   localparam logic [15:0] VEC8 [12] = '{
      16'h8080, 16'h807F, 16'h7F80, 16'h7F7F,
      16'hFFFF, 16'h0000, 16'h80FF, 16'hFF80,
      16'h0155, 16'hAA01, 16'h5555, 16'hAAAA
   };

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic op4(input logic [3:0] a, input logic [3:0] b);
      logic signed [7:0] e;
      e = $signed(a) * $signed(b);
      @(negedge clk);
      a4 = a; b4 = b; start4 = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start4 = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(busy4 && !done4, "R5 busy4 held", {30'd0, busy4, done4}, 32'h2);
      @(posedge clk);
      @(negedge clk);
      chk(done4 && !busy4 && prod4 == e, "R4 product4",
          {done4, busy4, 22'd0, prod4}, {2'b10, 22'd0, e});
   endtask

   task automatic op8(input logic [7:0] a, input logic [7:0] b);
      logic signed [15:0] e;
      e = $signed(a) * $signed(b);
      @(negedge clk);
      a8 = a; b8 = b; start8 = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start8 = 1'b0;
      repeat (7) @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      chk(done8 && !busy8 && prod8 == e, "R4 product8",
          {done8, busy8, 14'd0, prod8}, {2'b10, 14'd0, e});
   endtask

   task automatic steps4(input logic [3:0] b, input logic [7:0] e1, input logic [7:0] e2);
      @(negedge clk);
      a4 = 4'd1; b4 = b; start4 = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start4 = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(prod4 == e1, "R3 step1", {24'd0, prod4}, {24'd0, e1});
      @(posedge clk);
      @(negedge clk);
      chk(prod4 == e2, "R3 step2", {24'd0, prod4}, {24'd0, e2});
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(done4 && prod4 == {{4{b[3]}}, b}, "R3 final", {24'd0, prod4}, {24'd0, {4{b[3]}}, b});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (2) @(negedge clk);
      chk(!busy4 && !done4 && prod4 == '0, "R1 reset4", {22'd0, busy4, done4, prod4}, 32'd0);
      chk(!busy8 && !done8 && prod8 == '0, "R1 reset8", {14'd0, busy8, done8, prod8}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy4 && !done4 && prod4 == '0, "R1 after release", {22'd0, busy4, done4, prod4}, 32'd0);

      // R3: recoding of each pair, observed step by step
      steps4(4'd1, 8'hF8, 8'h04);
      steps4(4'd3, 8'hF8, 8'hFC);
      steps4(4'd2, 8'h00, 8'hF8);

      // R4: exhaustive 4-bit signed products
      for (int i = -8; i < 8; i++) begin
         for (int j = -8; j < 8; j++) begin
            op4(4'(i), 4'(j));
         end
      end

      // R4: corner table and random operands at width 8
      for (int k = 0; k < 12; k++) begin
         op8(VEC8[k][15:8], VEC8[k][7:0]);
      end
      for (int k = 0; k < 200; k++) begin
         op8(8'($urandom), 8'($urandom));
      end

      // R6 + R8: start held continuously, operands changed mid-run
      @(negedge clk);
      a4 = 4'd3; b4 = 4'hB; start4 = 1'b1;
      @(posedge clk);
      @(negedge clk);
      a4 = 4'd7; b4 = 4'd7;
      chk(busy4 && prod4 == '0, "R2 capture", {23'd0, busy4, prod4}, 32'h100);
      repeat (3) @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      chk(done4 && prod4 == 8'hF1, "R6 ignored start", {23'd0, done4, prod4}, 32'h1F1);
      a4 = 4'h8; b4 = 4'h8;
      @(posedge clk);
      @(negedge clk);
      start4 = 1'b0;
      chk(busy4 && !done4 && prod4 == '0, "R8 back-to-back accept",
          {22'd0, busy4, done4, prod4}, 32'h200);
      repeat (3) @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      chk(done4 && prod4 == 8'h40, "R8 second result", {23'd0, done4, prod4}, 32'h140);

      // R5 + R7: done one cycle, result held while idle
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk(!busy4 && !done4 && prod4 == 8'h40, "R7 hold",
             {22'd0, busy4, done4, prod4}, 32'h40);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule